// File: doc/BRIEF.md
# Queued Single-Word Wishbone Request Master

This block sits between an upstream request decoder and a Wishbone classic bus. The decoder delivers request beats, one per clock when `req_valid` is high. Each beat carries a direction (read or write), a 30-bit word address, 32-bit write data, four byte enables and start/end-of-packet marks. A multi-beat burst arrives as a run of beats, each carrying its own already-incremented address. The block issues exactly one single-word bus cycle per beat.

Beats are stored first in a 16-entry queue. The upstream side is allowed to send only while that queue is empty. Beats that were already in flight when permission fell are still absorbed. A beat that finds the queue full is discarded and latched as an error. Read data returned by the slave leaves the block as a one-cycle completion word, tagged with its address and packet marks, for the completion builder downstream.

Top module: `wb_req_bridge`

## Requirements
- R1: A beat with `req_write`=1 produces one bus cycle with `wb_we`=1, `wb_adr`=beat address, `wb_dat_o`=beat data and `wb_sel`=beat byte enables.
- R2: A beat with `req_write`=0 produces one bus cycle with `wb_we`=0, `wb_adr`=beat address and `wb_sel`=beat byte enables.
- R3: `wb_cyc` and `wb_stb` rise together on the clock after the master sees a queued beat while idle. They stay high, with `wb_we`, `wb_adr`, `wb_dat_o` and `wb_sel` unchanged, until a clock edge with `wb_ack`=1. On the next clock both are low for one cycle before the next beat starts.
- R4: `req_ready` is 1 exactly when the queue holds no beats. A beat taken onto the bus no longer counts as held.
- R5: On the clock after an acknowledged read, `rd_valid` is 1 for one cycle. At the same time `rd_data` carries the `wb_dat_i` value seen with the acknowledge, and `rd_addr`, `rd_first` and `rd_last` carry the beat's address and marks. `rd_valid` stays 0 after writes.
- R6: Beats with `req_valid`=1 are accepted whatever the state of `req_ready`, as long as fewer than 16 beats are held at the start of the cycle. Accepted beats reach the bus in arrival order, one bus cycle each.
- R7: A beat that arrives while 16 beats are held is dropped, so it produces no bus cycle. `ovf_err` then goes to 1 and stays there until reset.
- R8: While `rst` is 1 at a clock edge, the queue is emptied and the bus cycle is abandoned. After that edge `wb_cyc`, `wb_stb`, `rd_valid` and `ovf_err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request beat present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_first | input | 1 | Beat opens a packet |
| req_last | input | 1 | Beat closes a packet |
| req_addr | input | 30 | Word address of the beat |
| req_data | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | Upstream may send (queue empty) |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 30 | Word address |
| wb_dat_o | output | 32 | Write data to slave |
| wb_sel | output | 4 | Byte selects |
| wb_dat_i | input | 32 | Read data from slave |
| wb_ack | input | 1 | Slave acknowledge |
| rd_valid | output | 1 | Read completion word valid |
| rd_data | output | 32 | Read data |
| rd_addr | output | 30 | Address of the read |
| rd_first | output | 1 | Packet-start mark of the read beat |
| rd_last | output | 1 | Packet-end mark of the read beat |
| ovf_err | output | 1 | Sticky queue-overflow flag |

## Verification
A corrupted pointer or occupancy count shows at the ports within one beat. The bus then either carries an address and data that differ from the beat expected next in arrival order, or `req_ready` disagrees with the true queue occupancy on the same cycle. A wrong sequencer state shows as a cycle that drops before its acknowledge, stays up after it, or starts with no beat queued, all visible within one clock. A mistaken full threshold shows only under a stalled slave: the number of acknowledged cycles after a 20-beat flood differs from 17, and `ovf_err` rises too early or not at all.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int unsigned WBB_AW = 30;
  localparam int unsigned WBB_DW = 32;
  localparam int unsigned WBB_SW = WBB_DW / 8;

  typedef struct packed {
    logic              we;
    logic              first;
    logic              last;
    logic [WBB_AW-1:0] adr;
    logic [WBB_DW-1:0] dat;
    logic [WBB_SW-1:0] sel;
  } wbb_req_t;

  // circular pointer advance for a queue of arbitrary depth
  function automatic int unsigned wbb_ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of push/pop
  function automatic int unsigned wbb_occ_next(input int unsigned occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/wbb_req_fifo.sv
module wbb_req_fifo
  import wbb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  wbb_req_t din,
  input  logic     pop,
  output wbb_req_t dout,
  output logic     empty,
  output logic     full,
  output logic     drop
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  wbb_req_t        mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   occ;
  logic            do_push, do_pop;

  assign empty   = (occ == '0);
  assign full    = (occ == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= PW'(wbb_ptr_next(int'(wr_ptr), DEPTH));
      end
      if (do_pop)
        rd_ptr <= PW'(wbb_ptr_next(int'(rd_ptr), DEPTH));
      occ <= CW'(wbb_occ_next(int'(occ), do_push, do_pop));
    end
  end
endmodule

// File: rtl/wbb_issue.sv
module wbb_issue
  import wbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wbb_req_t          head,
  input  logic              head_vld,
  output logic              pop,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [WBB_AW-1:0] wb_adr,
  output logic [WBB_DW-1:0] wb_dat_o,
  output logic [WBB_SW-1:0] wb_sel,
  input  logic [WBB_DW-1:0] wb_dat_i,
  input  logic              wb_ack,
  output logic              rd_valid,
  output logic [WBB_DW-1:0] rd_data,
  output logic [WBB_AW-1:0] rd_addr,
  output logic              rd_first,
  output logic              rd_last
);
  typedef enum logic {ST_IDLE, ST_BUS} st_t;

  st_t      st;
  wbb_req_t cur;
  logic     done;

  assign pop      = (st == ST_IDLE) && head_vld;
  assign done     = (st == ST_BUS) && wb_ack;
  assign wb_cyc   = (st == ST_BUS);
  assign wb_stb   = (st == ST_BUS);
  assign wb_we    = cur.we;
  assign wb_adr   = cur.adr;
  assign wb_dat_o = cur.dat;
  assign wb_sel   = cur.sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_addr  <= '0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (pop) begin
        cur <= head;
        st  <= ST_BUS;
      end else if (done) begin
        st <= ST_IDLE;
        if (!cur.we) begin
          rd_valid <= 1'b1;
          rd_data  <= wb_dat_i;
          rd_addr  <= cur.adr;
          rd_first <= cur.first;
          rd_last  <= cur.last;
        end
      end
    end
  end
endmodule

// File: rtl/wb_req_bridge.sv
module wb_req_bridge
  import wbb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_first,
  input  logic              req_last,
  input  logic [WBB_AW-1:0] req_addr,
  input  logic [WBB_DW-1:0] req_data,
  input  logic [WBB_SW-1:0] req_be,
  output logic              req_ready,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [WBB_AW-1:0] wb_adr,
  output logic [WBB_DW-1:0] wb_dat_o,
  output logic [WBB_SW-1:0] wb_sel,
  input  logic [WBB_DW-1:0] wb_dat_i,
  input  logic              wb_ack,
  output logic              rd_valid,
  output logic [WBB_DW-1:0] rd_data,
  output logic [WBB_AW-1:0] rd_addr,
  output logic              rd_first,
  output logic              rd_last,
  output logic              ovf_err
);
  wbb_req_t beat, head;
  logic     q_empty, q_full, q_drop, issue_pop;

  assign beat = '{we: req_write, first: req_first, last: req_last,
                  adr: req_addr, dat: req_data, sel: req_be};

  wbb_req_fifo #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(req_valid), .din(beat), .pop(issue_pop),
    .dout(head), .empty(q_empty), .full(q_full), .drop(q_drop)
  );

  wbb_issue u_issue (
    .clk(clk), .rst(rst), .head(head), .head_vld(!q_empty), .pop(issue_pop),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_first(rd_first), .rd_last(rd_last)
  );

  assign req_ready = q_empty;

  always_ff @(posedge clk) begin
    if (rst)         ovf_err <= 1'b0;
    else if (q_drop) ovf_err <= 1'b1;
  end
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker
  import wbb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [WBB_AW-1:0] wb_adr,
  input logic [WBB_DW-1:0] wb_dat_o,
  input logic [WBB_SW-1:0] wb_sel,
  input logic              wb_ack,
  input logic              rd_valid,
  input logic              ovf_err,
  input logic              q_drop,
  input logic              issue_pop
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_we) && $stable(wb_adr)
                             && $stable(wb_dat_o) && $stable(wb_sel))); // R3
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_ack) |=> !wb_cyc); // R3
  AST_NO_POP_MID_CYCLE: assert property (@(posedge clk) disable iff (rst)
    issue_pop |-> !wb_cyc); // R3
  AST_READ_RETURN: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(wb_cyc && wb_ack && !wb_we)); // R5
  AST_NO_DROP_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !q_drop); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(q_drop)); // R7
endmodule

bind wb_req_bridge wbb_checker u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel),
  .wb_ack(wb_ack), .rd_valid(rd_valid), .ovf_err(ovf_err),
  .q_drop(q_drop), .issue_pop(issue_pop)
);

// File: tb/sim_wb_req_bridge.sv
module sim_wb_req_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_first = 1'b0, req_last = 1'b0;
  logic [29:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, wb_cyc, wb_stb, wb_we, rd_valid, rd_first, rd_last, ovf_err;
  logic [29:0] wb_adr, rd_addr;
  logic [31:0] wb_dat_o, rd_data;
  logic [3:0]  wb_sel;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack = 1'b0;

  always #5 clk = ~clk;

  wb_req_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_first(req_first), .req_last(req_last), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .req_ready(req_ready),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_first(rd_first), .rd_last(rd_last), .ovf_err(ovf_err)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct {
    bit we; bit first; bit last;
    logic [29:0] adr; logic [31:0] dat; logic [3:0] sel;
  } beat_t;

  beat_t       m_q[$];
  beat_t       m_cur;
  bit          m_busy = 0, m_ovf = 0, m_rdv = 0, m_rdf = 0, m_rdl = 0;
  logic [31:0] m_rdd = '0;
  logic [29:0] m_rda = '0;
  int          m_acks = 0, m_sz = 0;
  bit          m_was_busy = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_busy = 0; m_ovf = 0; m_rdv = 0;
    end else begin
      m_sz = m_q.size();
      m_was_busy = m_busy;
      m_rdv = 0;
      if (!m_was_busy && m_sz > 0) begin
        m_cur = m_q.pop_front();
        m_busy = 1;
      end else if (m_was_busy && wb_ack) begin
        m_busy = 0;
        m_acks++;
        if (!m_cur.we) begin
          m_rdv = 1; m_rdd = wb_dat_i; m_rda = m_cur.adr;
          m_rdf = m_cur.first; m_rdl = m_cur.last;
        end
      end
      if (req_valid) begin
        if (m_sz < 16)
          m_q.push_back('{req_write, req_first, req_last, req_addr, req_data, req_be});
        else
          m_ovf = 1;
      end
    end
  end

  // ---------------- per-cycle compare and slave ----------------
  int slave_lat = 0, wcnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 req_ready", 64'(req_ready), 64'(m_q.size() == 0));
      chk("R3 wb_cyc", 64'(wb_cyc), 64'(m_busy));
      chk("R3 wb_stb", 64'(wb_stb), 64'(m_busy));
      chk("R7 ovf_err", 64'(ovf_err), 64'(m_ovf));
      chk("R5 rd_valid", 64'(rd_valid), 64'(m_rdv));
      if (m_busy) begin
        chk(m_cur.we ? "R1 wb_we" : "R2 wb_we", 64'(wb_we), 64'(m_cur.we));
        chk(m_cur.we ? "R1 wb_adr" : "R2 wb_adr", 64'(wb_adr), 64'(m_cur.adr));
        chk(m_cur.we ? "R1 wb_sel" : "R2 wb_sel", 64'(wb_sel), 64'(m_cur.sel));
        if (m_cur.we) chk("R1 wb_dat_o", 64'(wb_dat_o), 64'(m_cur.dat));
      end
      if (m_rdv) begin
        chk("R5 rd_data", 64'(rd_data), 64'(m_rdd));
        chk("R5 rd_addr", 64'(rd_addr), 64'(m_rda));
        chk("R5 rd_marks", 64'({rd_first, rd_last}), 64'({m_rdf, m_rdl}));
      end
    end
    if (!wb_cyc) begin
      wcnt = 0; wb_ack = 1'b0;
    end else if (!wb_ack) begin
      if (wcnt >= slave_lat) begin
        wb_ack = 1'b1;
        wb_dat_i = {2'b00, wb_adr} ^ 32'hC35A_0F0F;
      end else wcnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit we, input bit f, input bit l, input logic [29:0] a,
                      input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_first = f; req_last = l;
    req_addr = a; req_data = d; req_be = s;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!(req_ready && !wb_cyc));
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc_cnt);
      summary();
      $finish;
    end
  end

  int a0;
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: state after reset
    chk("R8 reset cyc", 64'(wb_cyc), 64'd0);
    chk("R8 reset ready", 64'(req_ready), 64'd1);
    chk("R8 reset rdv", 64'(rd_valid), 64'd0);
    chk("R8 reset ovf", 64'(ovf_err), 64'd0);

    // R1: single write, immediate ack
    slave_lat = 0;
    send(1, 1, 1, 30'h0000_0100, 32'hDEAD_BEEF, 4'hF); idle(); drain();
    // R2 / R5: single read, slow slave
    slave_lat = 3;
    send(0, 1, 1, 30'h0000_0200, 32'h0, 4'h3); idle(); drain();
    // write burst with incrementing addresses
    slave_lat = 1;
    for (int i = 0; i < 5; i++)
      send(1, i == 0, i == 4, 30'h1000 + 30'(i), 32'hA000_0000 + 32'(i), 4'(i + 1));
    idle(); drain();
    // mixed read/write burst, R5 marks
    slave_lat = 2;
    for (int i = 0; i < 6; i++)
      send(i[0], i == 0, i == 5, 30'h2000 + 30'(i), 32'h5500_0000 + 32'(i), 4'hC);
    idle(); drain();

    // R6 / R7: flood of 20 beats into a stalled slave
    a0 = m_acks;
    slave_lat = 40;
    for (int i = 0; i < 20; i++)
      send(i % 3 == 0 ? 0 : 1, i == 0, i == 19, 30'h3000 + 30'(i), 32'h7700_0000 + 32'(i), 4'hF);
    idle();
    chk("R7 ovf raised", 64'(ovf_err), 64'd1);
    slave_lat = 0;
    drain();
    chk("R6 cycles after flood", 64'(m_acks - a0), 64'd17);
    chk("R7 ovf held", 64'(ovf_err), 64'd1);

    // R8: reset clears the sticky flag
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R8 ovf cleared", 64'(ovf_err), 64'd0);
    chk("R8 ready after reset", 64'(req_ready), 64'd1);

    summary();
    $finish;
  end
endmodule